// File: doc/BRIEF.md
# Single-Wire Serial Debug Monitor

This block lets a host debug a system over a single shared open-drain data line. The host sends 8N1 bytes at a fixed bit period. The block echoes every byte it receives and decodes a small command set: direct read, direct write, indexed read, indexed write, stack-pointer readout and return-to-program. It reaches memory through a simple synchronous port. It reads a stack-pointer value from an input and raises a one-cycle run request toward the surrounding system.

The line is never driven high. The block only pulls it low, an external pull-up restores the idle level, and the host sees the wired-AND of both sides. The bit period is taken from a strap input on the first clock after reset, and later changes to the strap are ignored. The receiver only listens in the four byte-accepting states, so the block never hears its own transmission.

The controller states are: `ST_OPCODE`, `ST_ADDR_HI`, `ST_ADDR_LO` and `ST_WDATA`, which wait for a byte. `ST_LAUNCH` starts the transmitter, and `ST_XMIT` waits for it to finish. `ST_MEM_RD` and `ST_MEM_CAP` issue a read and capture its data. `ST_MEM_WR` issues the write. `ST_SP_HI` and `ST_SP_LO` load the stack-pointer bytes, and `ST_RUN` issues the run pulse.

The transitions are:
- A received byte in any receiving state moves to `ST_LAUNCH`, so the byte is echoed, and records where to go after the echo.
- `ST_LAUNCH` goes to `ST_XMIT`.
- On transmit-done, `ST_XMIT` goes to the recorded state.
- `ST_MEM_RD` goes to `ST_MEM_CAP`, which goes to `ST_LAUNCH` to send the result.
- `ST_SP_HI` goes to `ST_LAUNCH` with `ST_SP_LO` recorded as the follow-on, and `ST_SP_LO` goes to `ST_LAUNCH` with `ST_OPCODE` recorded.
- `ST_MEM_WR` and `ST_RUN` return to `ST_OPCODE`.

The receiver has its own states:
- `RX_IDLE` waits for a falling edge.
- `RX_START` checks the line at mid-bit.
- `RX_DATA` takes eight mid-bit samples.
- `RX_STOP` checks the stop bit.
- `RX_TAIL` waits out the rest of the stop bit.

The transmitter states are `TX_IDLE` and `TX_SHIFT`.

Top module: `mon_top`

## Requirements
- R1: While reset is held and afterwards until a byte arrives, line_drive_low, mem_rd, mem_wr and run_req are 0. The address pointer resets to 0x0000.
- R2: Framing in both directions is 8N1 at the current bit period:
  - a low start bit comes first, then eight data bits least significant first, then a high stop bit;
  - line_drive_low=1 pulls the line low;
  - every accepted byte is sent back unchanged before the command continues;
  - the receiver is disabled while the block transmits.
- R3: The bit period is BIT_HI clock cycles if baud_strap is 1 on the first clock after reset, and BIT_LO cycles if it is 0. Later strap changes have no effect.
- R4: READ (opcode 0x4A) takes an address high byte, then a low byte, each echoed. It sets the pointer to that address and sends back one byte from memory. A read asserts mem_rd with mem_addr for one cycle, and mem_rdata is taken on the next cycle.
- R5: WRITE (0x49) takes address high, address low and one data byte, each echoed. It sets the pointer and pulses mem_wr, with mem_addr and mem_wdata, in the cycle after the data echo ends. No result byte is sent.
- R6: IWRITE (0x19) takes one data byte, echoed, and writes it to pointer+1, which becomes the new pointer.
- R7: IREAD (0x1A) advances the pointer by one and sends back the byte at the new pointer.
- R8: READSP (0x0C) sends sp_in[15:8], then sp_in[7:0].
- R9: RUN (0x28) pulses run_req for exactly one cycle, right after its echo completes.
- R10: A low level that is high again at the mid-point of the start bit is rejected. Nothing is echoed.
- R11: A byte whose stop bit samples low is discarded without an echo. Reception restarts only on a new falling edge.
- R12: Any other opcode is echoed and then ignored. It causes no memory access and no further transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_strap | input | 1 | Bit-period select, taken once after reset (1 = BIT_HI) |
| line_in | input | 1 | Level of the shared data line |
| line_drive_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| sp_in | input | 16 | Stack-pointer value to report |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data is expected on mem_rdata next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| run_req | output | 1 | One-cycle request to resume the user program |

## Verification
The assertions assume a host that waits for each echo before sending its next byte. Under that assumption, no byte arrives while the block is transmitting and the run, read and write strobes always follow a completed echo. The bench host model keeps to this: it sends one byte, decodes the echo or result bytes, and idles at least one bit period before the next byte. It never sends while it expects a reply. The line errors it injects (a short low glitch and a low stop bit) are placed only in idle gaps. memory serves reads with exactly one cycle of latency, as the port assumes.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [BYTE_W-1:0] OP_READ   = 8'h4A;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h49;
    localparam logic [BYTE_W-1:0] OP_IREAD  = 8'h1A;
    localparam logic [BYTE_W-1:0] OP_IWRITE = 8'h19;
    localparam logic [BYTE_W-1:0] OP_READSP = 8'h0C;
    localparam logic [BYTE_W-1:0] OP_RUN    = 8'h28;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_LAUNCH,
        ST_XMIT,
        ST_MEM_RD,
        ST_MEM_CAP,
        ST_MEM_WR,
        ST_SP_HI,
        ST_SP_LO,
        ST_RUN
    } ctl_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_TAIL
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_t;

endpackage

// File: rtl/mon_baud.sv
module mon_baud #(
    parameter int BIT_HI = 1024,
    parameter int BIT_LO = 512,
    parameter int CW     = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap,
    output logic [CW-1:0] bit_len,
    output logic [CW-1:0] half_len,
    output logic          sel_hi,
    output logic          ready
);

    // The strap is taken once, on the first clock after reset, and then held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_hi <= 1'b0;
            ready  <= 1'b0;
        end else if (!ready) begin
            sel_hi <= strap;
            ready  <= 1'b1;
        end
    end

    assign bit_len  = sel_hi ? CW'(BIT_HI) : CW'(BIT_LO);
    assign half_len = bit_len >> 1;

endmodule

// File: rtl/mon_rx.sv
module mon_rx
    import mon_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              enable,
    input  logic [CW-1:0]     bit_len,
    input  logic [CW-1:0]     half_len,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);

    logic s1_q, s2_q, s3_q;
    rx_state_t st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [2:0] nbit_q;
    logic [BYTE_W-1:0] sh_q;
    logic tick_half, tick_bit, fall;

    assign fall      = s3_q & ~s2_q;
    assign tick_half = (cnt_q == half_len - CW'(1));
    assign tick_bit  = (cnt_q == bit_len - CW'(1));

    // Two-stage synchroniser, plus one more stage for falling-edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= line_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (enable && fall) st_d = RX_START;
            RX_START: if (tick_half) st_d = s2_q ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_bit && nbit_q == 3'd7) st_d = RX_STOP;
            RX_STOP:  if (tick_bit) st_d = s2_q ? RX_TAIL : RX_IDLE;
            RX_TAIL:  if (tick_half) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            nbit_q <= '0;
            sh_q   <= '0;
            valid  <= 1'b0;
        end else begin
            if (st_q == RX_IDLE || st_q != st_d || (st_q == RX_DATA && tick_bit))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CW'(1);
            if (st_q == RX_START)
                nbit_q <= '0;
            else if (st_q == RX_DATA && tick_bit)
                nbit_q <= nbit_q + 3'd1;
            if (st_q == RX_DATA && tick_bit)
                sh_q <= {s2_q, sh_q[BYTE_W-1:1]};
            valid <= (st_q == RX_TAIL) && tick_half;
        end
    end

    assign data = sh_q;

endmodule

// File: rtl/mon_tx.sv
module mon_tx
    import mon_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [CW-1:0]     bit_len,
    output logic              drive_low,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_W = BYTE_W + 2;

    tx_state_t st_q, st_d;
    logic [FRAME_W-1:0] frame_q;
    logic [CW-1:0] cnt_q;
    logic [3:0] nbit_q;
    logic tick, last;

    assign tick = (cnt_q == bit_len - CW'(1));
    assign last = tick && (nbit_q == 4'(FRAME_W - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (start) st_d = TX_SHIFT;
            TX_SHIFT: if (last) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '1;
            cnt_q   <= '0;
            nbit_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= (st_q == TX_SHIFT) && last;
            if (st_q == TX_IDLE) begin
                cnt_q  <= '0;
                nbit_q <= '0;
                if (start) frame_q <= {1'b1, byte_in, 1'b0};
            end else if (tick) begin
                cnt_q   <= '0;
                nbit_q  <= nbit_q + 4'd1;
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy      = (st_q == TX_SHIFT);
    assign drive_low = busy && !frame_q[0];

endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_done,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              rx_en,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              run_req
);

    ctl_state_t st_q, st_d, after_q, after_d;
    logic [BYTE_W-1:0] cmd_q, hi_q, byte_q;
    logic [ADDR_W-1:0] ptr_q;

    function automatic ctl_state_t after_opcode(input logic [BYTE_W-1:0] op);
        ctl_state_t s;
        case (op)
            OP_READ, OP_WRITE: s = ST_ADDR_HI;
            OP_IREAD:          s = ST_MEM_RD;
            OP_IWRITE:         s = ST_WDATA;
            OP_READSP:         s = ST_SP_HI;
            OP_RUN:            s = ST_RUN;
            default:           s = ST_OPCODE;
        endcase
        return s;
    endfunction

    always_comb begin
        st_d    = st_q;
        after_d = after_q;
        unique case (st_q)
            ST_OPCODE: if (rx_valid) begin
                st_d    = ST_LAUNCH;
                after_d = after_opcode(rx_data);
            end
            ST_ADDR_HI: if (rx_valid) begin
                st_d    = ST_LAUNCH;
                after_d = ST_ADDR_LO;
            end
            ST_ADDR_LO: if (rx_valid) begin
                st_d    = ST_LAUNCH;
                after_d = (cmd_q == OP_READ) ? ST_MEM_RD : ST_WDATA;
            end
            ST_WDATA: if (rx_valid) begin
                st_d    = ST_LAUNCH;
                after_d = ST_MEM_WR;
            end
            ST_LAUNCH:  st_d = ST_XMIT;
            ST_XMIT:    if (tx_done) st_d = after_q;
            ST_MEM_RD:  st_d = ST_MEM_CAP;
            ST_MEM_CAP: begin
                st_d    = ST_LAUNCH;
                after_d = ST_OPCODE;
            end
            ST_MEM_WR:  st_d = ST_OPCODE;
            ST_SP_HI: begin
                st_d    = ST_LAUNCH;
                after_d = ST_SP_LO;
            end
            ST_SP_LO: begin
                st_d    = ST_LAUNCH;
                after_d = ST_OPCODE;
            end
            ST_RUN:     st_d = ST_OPCODE;
            default:    st_d = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_OPCODE;
            after_q <= ST_OPCODE;
        end else begin
            st_q    <= st_d;
            after_q <= after_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            hi_q   <= '0;
            byte_q <= '0;
            ptr_q  <= '0;
        end else begin
            case (st_q)
                ST_OPCODE: if (rx_valid) begin
                    cmd_q  <= rx_data;
                    byte_q <= rx_data;
                    if (rx_data == OP_IREAD || rx_data == OP_IWRITE)
                        ptr_q <= ptr_q + ADDR_W'(1);
                end
                ST_ADDR_HI: if (rx_valid) begin
                    hi_q   <= rx_data;
                    byte_q <= rx_data;
                end
                ST_ADDR_LO: if (rx_valid) begin
                    ptr_q  <= {hi_q, rx_data};
                    byte_q <= rx_data;
                end
                ST_WDATA:   if (rx_valid) byte_q <= rx_data;
                ST_MEM_CAP: byte_q <= mem_rdata;
                ST_SP_HI:   byte_q <= sp_in[ADDR_W-1:BYTE_W];
                ST_SP_LO:   byte_q <= sp_in[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rx_en     = (st_q == ST_OPCODE) || (st_q == ST_ADDR_HI) ||
                    (st_q == ST_ADDR_LO) || (st_q == ST_WDATA);
        tx_start  = (st_q == ST_LAUNCH);
        tx_byte   = byte_q;
        mem_rd    = (st_q == ST_MEM_RD);
        mem_wr    = (st_q == ST_MEM_WR);
        mem_addr  = ptr_q;
        mem_wdata = byte_q;
        run_req   = (st_q == ST_RUN);
    end

endmodule

// File: rtl/mon_top.sv
module mon_top
    import mon_pkg::*;
#(
    parameter int BIT_HI = 1024,
    parameter int BIT_LO = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_strap,
    input  logic        line_in,
    output logic        line_drive_low,
    input  logic [15:0] sp_in,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        run_req
);

    localparam int CW = $clog2(BIT_HI + 1);

    logic [CW-1:0] bit_len, half_len;
    logic baud_hi, baud_ready;
    logic rx_en, rx_valid;
    logic [BYTE_W-1:0] rx_data, tx_byte;
    logic tx_start, tx_busy, tx_done;

    mon_baud #(.BIT_HI(BIT_HI), .BIT_LO(BIT_LO), .CW(CW)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (baud_strap),
        .bit_len  (bit_len),
        .half_len (half_len),
        .sel_hi   (baud_hi),
        .ready    (baud_ready)
    );

    mon_rx #(.CW(CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .enable   (rx_en),
        .bit_len  (bit_len),
        .half_len (half_len),
        .valid    (rx_valid),
        .data     (rx_data)
    );

    mon_tx #(.CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tx_start),
        .byte_in   (tx_byte),
        .bit_len   (bit_len),
        .drive_low (line_drive_low),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    mon_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_done   (tx_done),
        .mem_rdata (mem_rdata),
        .sp_in     (sp_in),
        .rx_en     (rx_en),
        .tx_start  (tx_start),
        .tx_byte   (tx_byte),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .run_req   (run_req)
    );

endmodule

// File: rtl/mon_top_chk.sv
module mon_top_chk (
    input logic clk,
    input logic rst_n,
    input logic line_drive_low,
    input logic mem_rd,
    input logic mem_wr,
    input logic run_req,
    input logic rx_en,
    input logic tx_busy,
    input logic tx_done,
    input logic baud_hi,
    input logic baud_ready
);

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !line_drive_low);

    // R2
    half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_en);

    // R3
    baud_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_ready |=> $stable(baud_hi));

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5
    wr_after_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(tx_done));

    // R7
    rd_after_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(tx_done));

    // R9
    run_after_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |-> $past(tx_done));

    // R9
    run_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |=> !run_req);

endmodule

bind mon_top mon_top_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_drive_low (line_drive_low),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .run_req        (run_req),
    .rx_en          (rx_en),
    .tx_busy        (tx_busy),
    .tx_done        (tx_done),
    .baud_hi        (baud_hi),
    .baud_ready     (baud_ready)
);

// File: tb/tb_mon_top.sv
`timescale 1ns/1ps
module tb_mon_top;

    localparam int PH = 32;
    localparam int PL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b1;
    logic host_low = 1'b0;
    logic dut_low;
    logic line;
    logic [15:0] sp = 16'hBEEF;
    logic [15:0] maddr;
    logic mrd, mwr, run;
    logic [7:0] mwd;
    logic [7:0] mrdata = 8'h00;

    always #4 clk = ~clk;

    assign line = !(host_low || dut_low);

    mon_top #(.BIT_HI(PH), .BIT_LO(PL)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_strap     (strap),
        .line_in        (line),
        .line_drive_low (dut_low),
        .sp_in          (sp),
        .mem_addr       (maddr),
        .mem_rd         (mrd),
        .mem_wr         (mwr),
        .mem_wdata      (mwd),
        .mem_rdata      (mrdata),
        .run_req        (run)
    );

    int errors = 0;
    int checks = 0;
    int P = PH;
    int drive_cycles = 0;
    int run_seen = 0;
    int exp_rd[$];
    int exp_wa[$];
    logic [7:0] exp_wd[$];
    logic [7:0] mem [int];

    function automatic logic [7:0] mval(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: synchronous read with one cycle of latency.
    always @(posedge clk) begin
        if (mrd) mrdata <= mval(maddr);
        if (mwr) mem[int'(maddr)] = mwd;
    end

    // Per-clock comparison against the expected memory activity.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mrd) begin
                check(exp_rd.size() > 0 && exp_rd[0] == int'(maddr), "R4", "read address",
                      int'(maddr), exp_rd.size() > 0 ? exp_rd[0] : -1);
                if (exp_rd.size() > 0) void'(exp_rd.pop_front());
            end
            if (mwr) begin
                check(exp_wa.size() > 0 && exp_wa[0] == int'(maddr) && exp_wd[0] == mwd,
                      "R5", "write addr/data", int'({maddr, mwd}),
                      exp_wa.size() > 0 ? ((exp_wa[0] << 8) | int'(exp_wd[0])) : -1);
                if (exp_wa.size() > 0) begin
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
            end
            if (run) run_seen++;
            if (dut_low) drive_cycles++;
        end
    end

    task automatic host_send(input logic [7:0] b, input bit good_stop = 1'b1);
        repeat (P) @(negedge clk);
        host_low = 1'b1;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_low = ~b[i];
            repeat (P) @(negedge clk);
        end
        host_low = !good_stop;
        repeat (P) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic host_recv(output logic [7:0] b, output int lowrun, output bit got);
        int t = 0;
        bit seen = 0;
        b = 8'h00;
        lowrun = 0;
        got = 0;
        while (line && t < 40 * P) begin
            @(negedge clk);
            t++;
        end
        if (line) return;
        lowrun = 1;
        for (int n = 1; n <= P + P / 2; n++) begin
            @(negedge clk);
            if (!seen && !line) lowrun++;
            else seen = 1;
        end
        b[0] = line;
        for (int i = 1; i < 8; i++) begin
            repeat (P) @(negedge clk);
            b[i] = line;
        end
        repeat (P) @(negedge clk);
        got = line;
    endtask

    task automatic xfer(input logic [7:0] b, input string req, output int lowrun);
        logic [7:0] r;
        bit got;
        host_send(b);
        host_recv(r, lowrun, got);
        check(got && r == b, req, "echo byte", int'(r), int'(b));
    endtask

    task automatic expect_byte(input logic [7:0] e, input string req);
        logic [7:0] r;
        int lr;
        bit got;
        host_recv(r, lr, got);
        check(got && r == e, req, "result byte", int'(r), int'(e));
    endtask

    task automatic quiet(input int n, input string req);
        int d0 = drive_cycles;
        repeat (n) @(negedge clk);
        check(drive_cycles == d0, req, "line stays released", drive_cycles - d0, 0);
    endtask

    task automatic do_reset(input bit s);
        rst_n = 1'b0;
        strap = s;
        P = s ? PH : PL;
        repeat (4) @(negedge clk);
        check(!dut_low && !mrd && !mwr && !run, "R1", "outputs in reset",
              int'({dut_low, mrd, mwr, run}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_all();
        int lr;
        int r0;
        // R1: reset state
        do_reset(1'b1);
        quiet(2 * P, "R1");

        // R4: direct read
        exp_rd.push_back(16'h1234);
        xfer(8'h4A, "R4", lr);
        xfer(8'h12, "R4", lr);
        xfer(8'h34, "R4", lr);
        expect_byte(mval(16'h1234), "R4");

        // R5: direct write, R3 bit period from the start-bit width
        xfer(8'h49, "R5", lr);
        check(lr == PH, "R3", "start bit cycles (strap high)", lr, PH);
        xfer(8'h20, "R5", lr);
        xfer(8'h00, "R5", lr);
        exp_wa.push_back(16'h2000);
        exp_wd.push_back(8'hA5);
        xfer(8'hA5, "R5", lr);
        repeat (P) @(negedge clk);
        check(exp_wa.size() == 0, "R5", "write issued", exp_wa.size(), 0);
        quiet(4 * P, "R5");

        // R6: indexed write to pointer+1
        exp_wa.push_back(16'h2001);
        exp_wd.push_back(8'h3C);
        xfer(8'h19, "R6", lr);
        xfer(8'h3C, "R6", lr);
        repeat (P) @(negedge clk);
        check(exp_wa.size() == 0, "R6", "indexed write issued", exp_wa.size(), 0);

        // R7: indexed read advances again
        exp_rd.push_back(16'h2002);
        xfer(8'h1A, "R7", lr);
        expect_byte(8'h02 ^ 8'h20 ^ 8'h5A, "R7");

        // R5 readback, then R7 from the new pointer
        exp_rd.push_back(16'h2000);
        xfer(8'h4A, "R4", lr);
        xfer(8'h20, "R4", lr);
        xfer(8'h00, "R4", lr);
        expect_byte(8'hA5, "R5");
        exp_rd.push_back(16'h2001);
        xfer(8'h1A, "R7", lr);
        expect_byte(8'h3C, "R6");

        // R8: stack pointer readout
        xfer(8'h0C, "R8", lr);
        expect_byte(8'hBE, "R8");
        expect_byte(8'hEF, "R8");

        // R9: run request
        r0 = run_seen;
        xfer(8'h28, "R9", lr);
        repeat (P) @(negedge clk);
        check(run_seen == r0 + 1, "R9", "run pulses", run_seen - r0, 1);

        // R12: unknown opcode, R2 receiver deaf to its own echo
        xfer(8'h77, "R12", lr);
        quiet(4 * P, "R12");
        quiet(12 * P, "R2");

        // R10: glitch shorter than half a bit
        repeat (P) @(negedge clk);
        host_low = 1'b1;
        repeat (P / 4) @(negedge clk);
        host_low = 1'b0;
        quiet(14 * P, "R10");

        // R11: low stop bit is discarded
        host_send(8'h0C, 1'b0);
        quiet(14 * P, "R11");
        xfer(8'h0C, "R11", lr);
        expect_byte(8'hBE, "R11");
        expect_byte(8'hEF, "R11");

        // R3: strap low, later strap changes ignored; R6 pointer back to 0
        do_reset(1'b0);
        strap = 1'b1;
        xfer(8'h77, "R3", lr);
        check(lr == PL, "R3", "start bit cycles (strap low)", lr, PL);
        exp_wa.push_back(16'h0001);
        exp_wd.push_back(8'h66);
        xfer(8'h19, "R6", lr);
        xfer(8'h66, "R6", lr);
        repeat (P) @(negedge clk);
        check(exp_wa.size() == 0, "R6", "write after reset at 0x0001", exp_wa.size(), 0);
        exp_rd.push_back(16'h1234);
        xfer(8'h4A, "R4", lr);
        xfer(8'h12, "R4", lr);
        xfer(8'h34, "R4", lr);
        expect_byte(mval(16'h1234), "R4");
        check(exp_rd.size() == 0, "R4", "reads outstanding", exp_rd.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (180000) @(posedge clk);
                check(1'b0, "R2", "watchdog expired", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule